// File: doc/BRIEF.md
# Bus Bridge Initialization Access Gate

This block sits beside a bus bridge and decides what the bridge may do before and after software declares setup finished. Software writes a control register holding a sticky "setup done" flag and a local-request enable. Until the flag is set, a bridge strapped as bus host keeps the bus grant for itself and arbitrates no one. A bridge strapped as a plain device answers every inbound access with a retry. Outbound accesses towards external devices are refused in both cases.

Once the flag is set, the host bridge shares the bus through a round-robin arbiter, and the device bridge accepts inbound accesses. Outbound accesses pass. A group of six bus-timing registers is then frozen against writes, while a second group of address and configuration registers stays writable. The flag clears only on reset. Requests from the bridge towards the local bus controller are passed on only while the local-request enable is set.

Top module: `bridge_init_gate`

## Requirements
- R1: After reset the setup flag and the local-request enable read 0, and every register in both groups reads 0.
- R2: Writing address 0 with data bit 0 at 1 sets the setup flag from the next cycle. Writing 0 there never clears it, and only reset clears it. A read of address 0 returns the flag in bit 0 and the local-request enable in bit 1, with the other bits at 0.
- R3: In host mode with the flag at 0, `br_gnt` is 1 and `ext_gnt` is 0 in every cycle, whatever the requests are.
- R4: In host mode with the flag at 1, the grants are registered and at most one slot holds a grant. Slot 0 is `br_req` and slot k is `ext_req[k-1]`. A holder keeps the grant while it requests. Otherwise the grant goes to the first requesting slot after the last granted one in cyclic order, and to no slot if none requests. After reset, the last granted slot counts as the highest slot.
- R5: In non-host mode, `br_gnt` and `ext_gnt` stay 0.
- R6: In the same cycle as `in_valid`, the access is answered with `in_retry` in non-host mode with the flag at 0, and with `in_accept` otherwise. Neither output is asserted without `in_valid`.
- R7: In the same cycle as `out_valid`, the access is answered with `out_abort` while the flag is 0 and with `out_allow` once it is 1.
- R8: Addresses 1 to 6 hold the locked group. They take writes while the flag is 0, and writes are ignored while it is 1.
- R9: Addresses 7 to 10 hold the open group, which takes writes whatever the flag is. Writes to unmapped addresses are ignored, and reads of unmapped addresses return 0.
- R10: `lb_req_out` equals `lb_req_in` while the local-request enable is 1 and is 0 otherwise. Data bit 1 of a write to address 0 sets the enable, at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_mode | input | 1 | Strap: 1 means the bridge acts as bus host |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | ADDR_W | Register write address |
| reg_wr_data | input | DATA_W | Register write data |
| reg_rd_addr | input | ADDR_W | Register read address |
| reg_rd_data | output | DATA_W | Register read data, combinational |
| br_req | input | 1 | The bridge's own bus request (slot 0) |
| ext_req | input | NUM_EXT | External bus requests |
| br_gnt | output | 1 | Bus grant to the bridge |
| ext_gnt | output | NUM_EXT | Bus grants to external requesters |
| in_valid | input | 1 | Inbound access present |
| in_accept | output | 1 | Inbound access accepted |
| in_retry | output | 1 | Inbound access told to retry |
| out_valid | input | 1 | Outbound access request |
| out_allow | output | 1 | Outbound access allowed |
| out_abort | output | 1 | Outbound access refused |
| lb_req_in | input | 1 | Bridge request towards the local bus controller |
| lb_req_out | output | 1 | Gated local bus request |

## Verification
The bench runs each strap mode through its whole life. It writes both register groups before and after setup, attempts to clear the flag, and writes an unmapped address. A design that leaves the timing group writable after setup, or locks the open group, would return stale or wrong data on readback. A flag that a 0 write could clear would reopen that group and bring back the self-grant. Under random requests, a wrong rotation pointer, a grant that lets go while still requested, or a self-grant that lingers in the cycle after setup shows up as a grant mismatch. In non-host mode, a grant that leaks out, a retry in the wrong mode, or an unmasked local request differs from the model on the cycle it happens.

// File: rtl/bgate_pkg.sv
package bgate_pkg;
   typedef enum logic [1:0] {
      ARB_OFF  = 2'd0,
      ARB_SELF = 2'd1,
      ARB_RR   = 2'd2
   } arb_mode_e;
endpackage

// File: rtl/bgate_regs.sv
module bgate_regs #(
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 4,
   parameter int NUM_LOCKED = 6,
   parameter int NUM_OPEN   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              init_done,
   output logic              req_en
);
   localparam int LOCK_BASE = 1;
   localparam int OPEN_BASE = LOCK_BASE + NUM_LOCKED;

   logic                  init_q, req_en_q;
   logic [DATA_W-1:0]     lk_q [NUM_LOCKED];
   logic [DATA_W-1:0]     op_q [NUM_OPEN];
   logic [NUM_LOCKED-1:0] lk_hit;
   logic [NUM_OPEN-1:0]   op_hit;
   logic                  ctl_hit;

   assign ctl_hit = wr_en && (wr_addr == '0);

   genvar gi;
   generate
      for (gi = 0; gi < NUM_LOCKED; gi++) begin : g_lock
         assign lk_hit[gi] = wr_en && !init_q && (wr_addr == ADDR_W'(LOCK_BASE + gi));
         // R8
         lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            init_q |=> $stable(lk_q[gi]));
      end
      for (gi = 0; gi < NUM_OPEN; gi++) begin : g_open
         assign op_hit[gi] = wr_en && (wr_addr == ADDR_W'(OPEN_BASE + gi));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_q   <= 1'b0;
         req_en_q <= 1'b0;
         for (int i = 0; i < NUM_LOCKED; i++) lk_q[i] <= '0;
         for (int i = 0; i < NUM_OPEN; i++)   op_q[i] <= '0;
      end else begin
         if (ctl_hit) begin
            if (wr_data[0]) init_q <= 1'b1;
            req_en_q <= wr_data[1];
         end
         for (int i = 0; i < NUM_LOCKED; i++)
            if (lk_hit[i]) lk_q[i] <= wr_data;
         for (int i = 0; i < NUM_OPEN; i++)
            if (op_hit[i]) op_q[i] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == '0) rd_data = DATA_W'({req_en_q, init_q});
      for (int i = 0; i < NUM_LOCKED; i++)
         if (rd_addr == ADDR_W'(LOCK_BASE + i)) rd_data = lk_q[i];
      for (int i = 0; i < NUM_OPEN; i++)
         if (rd_addr == ADDR_W'(OPEN_BASE + i)) rd_data = op_q[i];
   end

   assign init_done = init_q;
   assign req_en    = req_en_q;

   // R2
   init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_q |=> init_q);
endmodule

// File: rtl/bgate_arb.sv
module bgate_arb
   import bgate_pkg::*;
#(
   parameter int NUM_SLOTS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  arb_mode_e            mode,
   input  logic [NUM_SLOTS-1:0] req,
   output logic [NUM_SLOTS-1:0] gnt
);
   localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

   logic [NUM_SLOTS-1:0] gnt_q, gnt_d;
   logic [IDX_W-1:0]     last_q, last_d, pick;
   logic                 found, keep;
   int                   cand;

   always_comb begin
      found = 1'b0;
      pick  = '0;
      cand  = 0;
      for (int off = 1; off <= NUM_SLOTS; off++) begin
         cand = (int'(last_q) + off) % NUM_SLOTS;
         if (!found && req[IDX_W'(cand)]) begin
            found = 1'b1;
            pick  = IDX_W'(cand);
         end
      end
      keep = |(gnt_q & req);
   end

   always_comb begin
      gnt_d  = '0;
      last_d = last_q;
      unique case (mode)
         ARB_SELF: begin
            gnt_d[0] = 1'b1;
            last_d   = '0;
         end
         ARB_RR: begin
            if (keep) gnt_d = gnt_q;
            else if (found) begin
               gnt_d[pick] = 1'b1;
               last_d      = pick;
            end
         end
         default: gnt_d = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_q  <= '0;
         last_q <= IDX_W'(NUM_SLOTS - 1);
      end else begin
         gnt_q  <= gnt_d;
         last_q <= last_d;
      end
   end

   always_comb begin
      gnt = '0;
      if (mode == ARB_SELF) gnt[0] = 1'b1;
      else if (mode == ARB_RR) gnt = gnt_q;
   end

   // R4
   one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   // R4
   grant_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == ARB_RR && |(gnt_q & req)) |=> (mode != ARB_RR || gnt_q == $past(gnt_q)));
endmodule

// File: rtl/bgate_filter.sv
module bgate_filter (
   input  logic host,
   input  logic init_done,
   input  logic req_en,
   input  logic in_valid,
   input  logic out_valid,
   input  logic lb_req_in,
   output logic in_accept,
   output logic in_retry,
   output logic out_allow,
   output logic out_abort,
   output logic lb_req_out
);
   logic inbound_open;

   assign inbound_open = host || init_done;
   assign in_accept    = in_valid && inbound_open;
   assign in_retry     = in_valid && !inbound_open;
   assign out_allow    = out_valid && init_done;
   assign out_abort    = out_valid && !init_done;
   assign lb_req_out   = lb_req_in && req_en;

   // R6
   always_comb begin
      in_excl_chk: assert (!(in_accept && in_retry));
   end
endmodule

// File: rtl/bridge_init_gate.sv
module bridge_init_gate
   import bgate_pkg::*;
#(
   parameter int NUM_EXT    = 3,
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 4,
   parameter int NUM_LOCKED = 6,
   parameter int NUM_OPEN   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_mode,
   input  logic               reg_wr_en,
   input  logic [ADDR_W-1:0]  reg_wr_addr,
   input  logic [DATA_W-1:0]  reg_wr_data,
   input  logic [ADDR_W-1:0]  reg_rd_addr,
   output logic [DATA_W-1:0]  reg_rd_data,
   input  logic               br_req,
   input  logic [NUM_EXT-1:0] ext_req,
   output logic               br_gnt,
   output logic [NUM_EXT-1:0] ext_gnt,
   input  logic               in_valid,
   output logic               in_accept,
   output logic               in_retry,
   input  logic               out_valid,
   output logic               out_allow,
   output logic               out_abort,
   input  logic               lb_req_in,
   output logic               lb_req_out
);
   localparam int NUM_SLOTS = NUM_EXT + 1;
   localparam int NUM_ADDRS = 1 + NUM_LOCKED + NUM_OPEN;

   generate
      if (NUM_EXT < 1) begin : g_bad_ext
         $error("NUM_EXT must be at least 1");
      end
      if (NUM_ADDRS > (1 << ADDR_W)) begin : g_bad_map
         $error("register map does not fit ADDR_W");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W must hold the two control bits");
      end
   endgenerate

   logic                 init_done, req_en;
   arb_mode_e            mode;
   logic [NUM_SLOTS-1:0] slot_gnt;

   bgate_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .NUM_LOCKED(NUM_LOCKED), .NUM_OPEN(NUM_OPEN)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
      .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
      .init_done(init_done), .req_en(req_en)
   );

   always_comb begin
      if (!host_mode)     mode = ARB_OFF;
      else if (init_done) mode = ARB_RR;
      else                mode = ARB_SELF;
   end

   bgate_arb #(.NUM_SLOTS(NUM_SLOTS)) u_arb (
      .clk(clk), .rst_n(rst_n), .mode(mode),
      .req({ext_req, br_req}), .gnt(slot_gnt)
   );

   assign br_gnt  = slot_gnt[0];
   assign ext_gnt = slot_gnt[NUM_SLOTS-1:1];

   bgate_filter u_filt (
      .host(host_mode), .init_done(init_done), .req_en(req_en),
      .in_valid(in_valid), .out_valid(out_valid), .lb_req_in(lb_req_in),
      .in_accept(in_accept), .in_retry(in_retry),
      .out_allow(out_allow), .out_abort(out_abort), .lb_req_out(lb_req_out)
   );

   // R3
   self_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_mode && !init_done) |-> (br_gnt && ext_gnt == '0));
   // R5
   nonhost_nogrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !host_mode |-> (!br_gnt && ext_gnt == '0));
   // R6
   host_no_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_mode |-> !in_retry);
   // R7
   pre_init_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !init_done) |-> (out_abort && !out_allow));
   // R10
   lb_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lb_req_out |-> (req_en && lb_req_in));
endmodule

// File: tb/sim_bridge_init_gate.sv
module sim_bridge_init_gate;
   localparam int CLK_PERIOD = 10;
   localparam int NE = 3;
   localparam int DW = 16;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_mode = 1'b1;
   logic          reg_wr_en = 1'b0;
   logic [AW-1:0] reg_wr_addr = '0;
   logic [DW-1:0] reg_wr_data = '0;
   logic [AW-1:0] reg_rd_addr = '0;
   logic [DW-1:0] reg_rd_data;
   logic          br_req = 1'b0;
   logic [NE-1:0] ext_req = '0;
   logic          br_gnt;
   logic [NE-1:0] ext_gnt;
   logic          in_valid = 1'b0, in_accept, in_retry;
   logic          out_valid = 1'b0, out_allow, out_abort;
   logic          lb_req_in = 1'b0, lb_req_out;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   bridge_init_gate u0 (
      .clk(clk), .rst_n(rst_n), .host_mode(host_mode),
      .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
      .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
      .br_req(br_req), .ext_req(ext_req), .br_gnt(br_gnt), .ext_gnt(ext_gnt),
      .in_valid(in_valid), .in_accept(in_accept), .in_retry(in_retry),
      .out_valid(out_valid), .out_allow(out_allow), .out_abort(out_abort),
      .lb_req_in(lb_req_in), .lb_req_out(lb_req_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // reference model state
   bit        m_init, m_reqen;
   logic [DW-1:0] m_lk [6];
   logic [DW-1:0] m_op [4];
   int        m_holder, m_last;

   task automatic model_reset();
      m_init = 0; m_reqen = 0; m_holder = -1; m_last = NE;
      for (int i = 0; i < 6; i++) m_lk[i] = '0;
      for (int i = 0; i < 4; i++) m_op[i] = '0;
   endtask

   task automatic chk(string rq, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", rq, what, act, exp, $time);
      end
   endtask

   initial model_reset();

   always @(negedge clk) begin
      bit force_self, off;
      logic [NE:0] gv, slots;
      int a, rd_exp, found;
      string rg, rr, rdq;
      if (!rst_n) model_reset();
      force_self = host_mode && !m_init;
      off = !host_mode;
      gv = '0;
      if (force_self) gv[0] = 1'b1;
      else if (!off && m_holder >= 0) gv[m_holder] = 1'b1;
      rg = !rst_n ? "R1" : force_self ? "R3" : off ? "R5" : "R4";
      rr = !rst_n ? "R1" : "R6";
      chk(rg, "br_gnt", int'(br_gnt), int'(gv[0]));
      chk(rg, "ext_gnt", int'(ext_gnt), int'(gv[NE:1]));
      chk(rr, "in_accept", int'(in_accept), int'(in_valid && (host_mode || m_init)));
      chk(rr, "in_retry", int'(in_retry), int'(in_valid && !host_mode && !m_init));
      chk(!rst_n ? "R1" : "R7", "out_allow", int'(out_allow), int'(out_valid && m_init));
      chk(!rst_n ? "R1" : "R7", "out_abort", int'(out_abort), int'(out_valid && !m_init));
      chk(!rst_n ? "R1" : "R10", "lb_req_out", int'(lb_req_out), int'(lb_req_in && m_reqen));
      a = int'(reg_rd_addr);
      if (a == 0) begin rd_exp = int'(m_reqen) * 2 + int'(m_init); rdq = "R2"; end
      else if (a <= 6) begin rd_exp = int'(m_lk[a-1]); rdq = "R8"; end
      else if (a <= 10) begin rd_exp = int'(m_op[a-7]); rdq = "R9"; end
      else begin rd_exp = 0; rdq = "R9"; end
      if (!rst_n) rdq = "R1";
      chk(rdq, "reg_rd_data", int'(reg_rd_data), rd_exp);
      if (rst_n) begin
         slots = {ext_req, br_req};
         if (force_self) begin m_holder = 0; m_last = 0; end
         else if (off) m_holder = -1;
         else if (!(m_holder >= 0 && slots[m_holder])) begin
            found = -1;
            for (int k = 1; k <= NE + 1; k++)
               if (found < 0 && slots[(m_last + k) % (NE + 1)]) found = (m_last + k) % (NE + 1);
            m_holder = found;
            if (found >= 0) m_last = found;
         end
         if (reg_wr_en) begin
            a = int'(reg_wr_addr);
            if (a == 0) begin
               if (reg_wr_data[0]) m_init = 1;
               m_reqen = reg_wr_data[1];
            end else if (a <= 6) begin
               if (!m_init) m_lk[a-1] = reg_wr_data;
            end else if (a <= 10) m_op[a-7] = reg_wr_data;
         end
      end
   end

   task automatic step(int t);
      @(posedge clk); #1;
      ext_req     = NE'($urandom);
      br_req      = 1'($urandom);
      in_valid    = 1'($urandom);
      out_valid   = 1'($urandom);
      lb_req_in   = 1'($urandom);
      reg_rd_addr = AW'($urandom % 12);
      reg_wr_en   = 1'b0;
      reg_wr_data = DW'($urandom);
      if (t >= 5 && t <= 10) begin reg_wr_en = 1; reg_wr_addr = AW'(t - 4); end      // R8 before setup
      if (t >= 12 && t <= 15) begin reg_wr_en = 1; reg_wr_addr = AW'(t - 5); end     // R9
      if (t == 20 || t == 60 || t == 300) begin reg_wr_en = 1; reg_wr_addr = '0; reg_wr_data = 16'h0002; end // R10
      if (t == 40) begin reg_wr_en = 1; reg_wr_addr = '0; reg_wr_data = 16'h0000; end
      if (t == 100) begin reg_wr_en = 1; reg_wr_addr = '0; reg_wr_data = 16'h0003; end // R2 set
      if (t >= 110 && t <= 115) begin reg_wr_en = 1; reg_wr_addr = AW'(t - 109); end  // R8 locked
      if (t >= 120 && t <= 123) begin reg_wr_en = 1; reg_wr_addr = AW'(t - 113); end  // R9 after setup
      if (t == 200) begin reg_wr_en = 1; reg_wr_addr = '0; reg_wr_data = 16'hFFFE; end // R2 clear attempt
      if (t == 400) begin reg_wr_en = 1; reg_wr_addr = AW'(12); end                   // R9 unmapped
   endtask

   initial begin
      for (int ph = 0; ph < 2; ph++) begin
         @(posedge clk); #1;
         rst_n = 1'b0;
         reg_wr_en = 1'b0;
         host_mode = (ph == 0);
         for (int r = 0; r < 4; r++) begin
            @(posedge clk); #1;
            reg_rd_addr = AW'(r * 3);   // R1 reset readback
            ext_req = NE'($urandom); br_req = 1'($urandom);
         end
         rst_n = 1'b1;
         for (int t = 0; t < 500; t++) step(t);
      end
      @(posedge clk); #1;
      reg_wr_en = 1'b0;
      @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule